// File: doc/BRIEF.md
# Scoreboard-Gated Instruction Issue Controller

This block decides when the next instruction of a single warp may issue. Each instruction arrives with scheduling metadata that the compiler placed beside it. The metadata holds a 4-bit hold count, a 6-bit set of dependency slots to wait on, and one or two slot claims: one for the result and one for the source operands. It also carries a hint that the warp may be switched out. The block does not look at register names. It follows only these software-assigned slots and the static hold counts.

Six dependency slots are kept as busy flags. An issuing instruction that names a slot in its result or operand claim marks that slot busy. A one-cycle completion pulse from the execution side clears it again. A later consumer names the slot in its wait set and is held until the slot is clear. The hold count of the presented instruction runs at the same time as the slot wait. The instruction is accepted through a valid/ready handshake. The hint leaves the block as a one-cycle request to an outer warp selector. A claim on a slot that is still busy raises a one-cycle error flag, and the instruction issues anyway.

Top module: `dep_issue_gate`

## Requirements
- R1: After reset all six slots read clear on `slot_busy`, and `yield_req` and `claim_err` are low.
- R2: An instruction first presented in cycle t with hold count S (0 to 15) and no blocking slot sees `in_ready` high first in cycle t+S. With S=0 it is ready in cycle t itself.
- R3: While any slot whose bit is set in `in_wait_mask` (bit N = slot N) is busy, `in_ready` is low. Once the last such slot clears and the hold count has expired, `in_ready` goes high.
- R4: An instruction that issues (`in_valid && in_ready` at a clock edge) with `in_wr_slot` in 0..5 sets that slot's bit in `slot_busy` from the next cycle. Codes 6 and 7 claim nothing.
- R5: An issuing instruction with `in_rd_slot` in 0..5 sets that slot's bit in `slot_busy` from the next cycle. Codes 6 and 7 claim nothing.
- R6: A pulse on `cpl_pulse[N]` clears slot N from the next cycle. A pulse on a slot that is already clear leaves `slot_busy` unchanged.
- R7: When an issue claims slot N in the same cycle that `cpl_pulse[N]` is high, slot N stays busy.
- R8: When an issuing instruction claims a slot that is busy in its issue cycle, `claim_err` is high for exactly the following cycle. The instruction still issues and the slot stays busy.
- R9: `yield_req` is high for exactly the cycle after an instruction with `in_yield=1` issues. `in_yield` never changes `in_ready`.
- R10: A busy slot whose bit is clear in `in_wait_mask` does not hold the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction metadata is presented |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_stall | input | 4 | Hold count, in cycles, before issue |
| in_wr_slot | input | 3 | Result claim slot: 0..5, or 6/7 for none |
| in_rd_slot | input | 3 | Operand claim slot: 0..5, or 6/7 for none |
| in_wait_mask | input | 6 | Slots that must be clear before issue |
| in_yield | input | 1 | Warp-switch hint |
| cpl_pulse | input | 6 | Per-slot completion pulse |
| slot_busy | output | 6 | Current busy flag of each slot |
| yield_req | output | 1 | One-cycle warp-switch request after a hinted issue |
| claim_err | output | 1 | One-cycle flag after a claim on a busy slot |

## Verification
The hold count is tried at 0, 1, 5 and 15 with no slot blocking. This tells an off-by-one in the countdown apart from a missing countdown. Slot waits are tried with the blocking slot masked and unmasked. A completion pulse is sent to a busy slot and also to a clear slot, which separates a correct mask from one that ignores the wait set or clears the wrong slot. A claim that lands on the same slot in the same cycle as its completion shows the claim-over-clear priority and the error flag at once. The same instruction is sent with the hint set and with it clear, to show that the hint only changes `yield_req` and never the timing.

// File: rtl/dep_issue_pkg.sv
// Shared constants and helpers for the issue controller.
// Assumes slot codes at or above NUM_SLOTS mean "no tracking".
package dep_issue_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int SLOT_W    = 3;
    localparam int STALL_W   = 4;
    localparam logic [SLOT_W-1:0] SLOT_NONE = 3'd7;

    // Turn a slot code into a one-hot claim vector; out-of-range codes give zero.
    function automatic logic [NUM_SLOTS-1:0] slot_decode(input logic [SLOT_W-1:0] code);
        logic [NUM_SLOTS-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (code == SLOT_W'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/hold_timer.sv
// Hold-count timer for the presented instruction.
// It starts counting in the first cycle an instruction is valid and reports
// expiry exactly STALL cycles later. It re-arms after each issue.
// Assumes the instruction stays valid and stable until it is accepted.
module hold_timer #(
    parameter int STALL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               present,
    input  logic               issue,
    input  logic [STALL_W-1:0] stall_val,
    output logic               expired
);
    logic               armed;
    logic [STALL_W-1:0] remain;

    // Expired when armed and at zero, or not yet armed with a zero hold.
    always_comb begin
        expired = armed ? (remain == '0) : (stall_val == '0);
    end

    // Arm on first presentation, count down, disarm on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            remain <= '0;
        end else if (issue) begin
            armed  <= 1'b0;
            remain <= '0;
        end else if (!armed) begin
            if (present && stall_val != '0) begin
                armed  <= 1'b1;
                remain <= stall_val - 1'b1;
            end
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/slot_board.sv
// Busy flags for the dependency slots.
// Each slot is set by a claim from an issuing instruction and cleared by its
// completion pulse. A claim beats a clear that arrives in the same cycle.
// It also reports whether any claimed slot was already busy.
module slot_board #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 claim_en,
    input  logic [SLOT_W-1:0]    wr_code,
    input  logic [SLOT_W-1:0]    rd_code,
    input  logic [NUM_SLOTS-1:0] cpl,
    output logic [NUM_SLOTS-1:0] busy,
    output logic                 claim_hit
);
    logic [NUM_SLOTS-1:0] claim_vec;

    // Merge both claim fields into one vector, gated by issue.
    always_comb begin
        claim_vec = claim_en ? (dep_issue_pkg::slot_decode(wr_code) |
                                dep_issue_pkg::slot_decode(rd_code)) : '0;
        claim_hit = |(claim_vec & busy);
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Per-slot flag: a claim wins, otherwise a completion clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)            busy[s] <= 1'b0;
            else if (claim_vec[s]) busy[s] <= 1'b1;
            else if (cpl[s])       busy[s] <= 1'b0;
        end
    end
endmodule

// File: rtl/dep_issue_gate.sv
// Issue controller for one warp.
// It holds the presented instruction until its hold count expires and every
// slot in its wait set is clear, then accepts it through valid/ready. It
// records the instruction's slot claims and emits one-cycle yield and claim
// error pulses. Assumes completion pulses come from the execution side.
module dep_issue_gate
    import dep_issue_pkg::*;
#(
    parameter int NSLOT  = NUM_SLOTS,
    parameter int SW     = SLOT_W,
    parameter int HOLD_W = STALL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HOLD_W-1:0] in_stall,
    input  logic [SW-1:0]     in_wr_slot,
    input  logic [SW-1:0]     in_rd_slot,
    input  logic [NSLOT-1:0]  in_wait_mask,
    input  logic              in_yield,
    input  logic [NSLOT-1:0]  cpl_pulse,
    output logic [NSLOT-1:0]  slot_busy,
    output logic              yield_req,
    output logic              claim_err
);
    logic hold_done;
    logic deps_clear;
    logic issue;
    logic hit;

    hold_timer #(.STALL_W(HOLD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .present   (in_valid),
        .issue     (issue),
        .stall_val (in_stall),
        .expired   (hold_done)
    );

    slot_board #(.NUM_SLOTS(NSLOT), .SLOT_W(SW)) u_board (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (issue),
        .wr_code   (in_wr_slot),
        .rd_code   (in_rd_slot),
        .cpl       (cpl_pulse),
        .busy      (slot_busy),
        .claim_hit (hit)
    );

    // Ready when the hold has expired and no waited-on slot is busy.
    always_comb begin
        deps_clear = (in_wait_mask & slot_busy) == '0;
        in_ready   = hold_done && deps_clear;
        issue      = in_valid && in_ready;
    end

    // One-cycle pulses that follow an issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yield_req <= 1'b0;
            claim_err <= 1'b0;
        end else begin
            yield_req <= issue && in_yield;
            claim_err <= issue && hit;
        end
    end
endmodule

// File: rtl/dep_issue_gate_chk.sv
// Property checker for dep_issue_gate, attached with bind.
// Watches only ports of the top module.
module dep_issue_gate_chk #(
    parameter int NSLOT = 6,
    parameter int SW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [SW-1:0]    in_wr_slot,
    input logic [SW-1:0]    in_rd_slot,
    input logic [NSLOT-1:0] in_wait_mask,
    input logic             in_yield,
    input logic [NSLOT-1:0] cpl_pulse,
    input logic [NSLOT-1:0] slot_busy,
    input logic             yield_req,
    input logic             claim_err
);
    // R3
    wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ((in_wait_mask & slot_busy) == '0));

    // R4
    wr_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
        ((slot_busy & $past(dep_issue_pkg::slot_decode(in_wr_slot)))
         == $past(dep_issue_pkg::slot_decode(in_wr_slot))));

    // R5
    rd_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
        ((slot_busy & $past(dep_issue_pkg::slot_decode(in_rd_slot)))
         == $past(dep_issue_pkg::slot_decode(in_rd_slot))));

    // R9
    yield_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req |-> $past(in_valid && in_ready && in_yield));

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_err |-> $past(in_valid && in_ready));

    for (genvar s = 0; s < NSLOT; s++) begin : g_clr
        // R6
        clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(slot_busy[s]) |-> $past(cpl_pulse[s]));
    end
endmodule

bind dep_issue_gate dep_issue_gate_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_wr_slot   (in_wr_slot),
    .in_rd_slot   (in_rd_slot),
    .in_wait_mask (in_wait_mask),
    .in_yield     (in_yield),
    .cpl_pulse    (cpl_pulse),
    .slot_busy    (slot_busy),
    .yield_req    (yield_req),
    .claim_err    (claim_err)
);

// File: tb/dep_issue_gate_tb.sv
// Directed bench for dep_issue_gate: one task per scenario.
// Inputs change on the falling edge, outputs are sampled 1 ns later.
module dep_issue_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_stall = '0;
    logic [2:0] in_wr_slot = 3'd7;
    logic [2:0] in_rd_slot = 3'd7;
    logic [5:0] in_wait_mask = '0;
    logic       in_yield = 1'b0;
    logic [5:0] cpl_pulse = '0;
    logic [5:0] slot_busy;
    logic       yield_req;
    logic       claim_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dep_issue_gate u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_stall(in_stall), .in_wr_slot(in_wr_slot), .in_rd_slot(in_rd_slot),
        .in_wait_mask(in_wait_mask), .in_yield(in_yield), .cpl_pulse(cpl_pulse),
        .slot_busy(slot_busy), .yield_req(yield_req), .claim_err(claim_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one cycle: next falling edge, then settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic present(input logic [3:0] st, input logic [2:0] wr,
                           input logic [2:0] rd, input logic [5:0] msk,
                           input logic y);
        in_valid = 1'b1; in_stall = st; in_wr_slot = wr;
        in_rd_slot = rd; in_wait_mask = msk; in_yield = y;
        #1;
    endtask

    // Take the presented instruction at the next edge (it must be ready).
    task automatic accept();
        @(negedge clk);
        in_valid = 1'b0; in_stall = '0; in_wr_slot = 3'd7; in_rd_slot = 3'd7;
        in_wait_mask = '0; in_yield = 1'b0; cpl_pulse = '0;
        #1;
    endtask

    // Count cycles until ready, up to a limit.
    task automatic cycles_to_ready(input int limit, output int n);
        n = 0;
        while (!in_ready && n < limit) begin
            step();
            n++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", int'(slot_busy), 0);
        check("R1 yield_req", int'(yield_req), 0);
        check("R1 claim_err", int'(claim_err), 0);
    endtask

    task automatic t_hold();
        int n;
        int vals[4] = '{0, 1, 5, 15};
        foreach (vals[i]) begin
            @(negedge clk);
            present(4'(vals[i]), 3'd7, 3'd7, 6'h00, 1'b0);
            cycles_to_ready(40, n);
            check($sformatf("R2 hold %0d", vals[i]), n, vals[i]);
            accept();
        end
    endtask

    task automatic t_claims();
        @(negedge clk);
        present(4'd0, 3'd2, 3'd7, 6'h00, 1'b0);
        accept();
        check("R4 write claim slot 2", int'(slot_busy), 6'b000100);
        @(negedge clk);
        present(4'd0, 3'd7, 3'd6, 6'h00, 1'b0);
        accept();
        @(negedge clk);
        present(4'd0, 3'd6, 3'd7, 6'h00, 1'b0);
        accept();
        check("R4 R5 codes 6 and 7 claim nothing", int'(slot_busy), 6'b000100);
        @(negedge clk);
        present(4'd0, 3'd7, 3'd4, 6'h00, 1'b0);
        accept();
        check("R5 operand claim slot 4", int'(slot_busy), 6'b010100);
    endtask

    task automatic t_wait();
        int n;
        @(negedge clk);
        present(4'd0, 3'd7, 3'd7, 6'b000001, 1'b0);
        check("R10 unmasked busy slots ignored", int'(in_ready), 1);
        accept();
        @(negedge clk);
        present(4'd1, 3'd7, 3'd7, 6'b000100, 1'b0);
        cycles_to_ready(4, n);
        check("R3 blocked by busy slot 2", int'(in_ready), 0);
        @(negedge clk);
        cpl_pulse = 6'b000100;
        @(negedge clk);
        cpl_pulse = '0;
        #1;
        check("R6 slot 2 cleared", int'(slot_busy), 6'b010000);
        check("R3 ready after clear", int'(in_ready), 1);
        accept();
        @(negedge clk);
        cpl_pulse = 6'b000001;
        step();
        cpl_pulse = '0;
        check("R6 pulse on clear slot no effect", int'(slot_busy), 6'b010000);
        @(negedge clk);
        cpl_pulse = 6'b010000;
        step();
        cpl_pulse = '0;
        check("R6 slot 4 cleared", int'(slot_busy), 0);
    endtask

    task automatic t_race();
        @(negedge clk);
        present(4'd0, 3'd3, 3'd7, 6'h00, 1'b0);
        accept();
        check("R8 no error on free claim", int'(claim_err), 0);
        @(negedge clk);
        present(4'd0, 3'd3, 3'd7, 6'h00, 1'b0);
        cpl_pulse = 6'b001000;
        check("R8 issues despite busy claim", int'(in_ready), 1);
        accept();
        check("R7 claim beats completion", int'(slot_busy), 6'b001000);
        check("R8 error pulse", int'(claim_err), 1);
        step();
        check("R8 error one cycle", int'(claim_err), 0);
        @(negedge clk);
        cpl_pulse = 6'b001000;
        step();
        cpl_pulse = '0;
        check("R6 slot 3 cleared", int'(slot_busy), 0);
    endtask

    task automatic t_yield();
        int n;
        @(negedge clk);
        present(4'd3, 3'd7, 3'd7, 6'h00, 1'b1);
        cycles_to_ready(20, n);
        check("R9 hint does not change hold", n, 3);
        accept();
        check("R9 yield pulse", int'(yield_req), 1);
        step();
        check("R9 yield one cycle", int'(yield_req), 0);
        @(negedge clk);
        present(4'd0, 3'd1, 3'd7, 6'h00, 1'b0);
        accept();
        check("R9 no yield without hint", int'(yield_req), 0);
        @(negedge clk);
        present(4'd0, 3'd7, 3'd7, 6'b000010, 1'b1);
        check("R9 hint does not release wait", int'(in_ready), 0);
        in_yield = 1'b0;
        #1;
        check("R9 hint clear still blocked", int'(in_ready), 0);
        cpl_pulse = 6'b000010;
        @(negedge clk);
        cpl_pulse = '0;
        #1;
        check("R3 ready after slot 1 clear", int'(in_ready), 1);
        accept();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_hold();
        t_claims();
        t_wait();
        t_race();
        t_yield();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule